// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block makes the acknowledge decision for the address phase of an I2C slave. The bus shifter delivers complete bytes together with one-cycle strobes for start, repeated start, stop and byte complete. The recognizer answers each byte that follows a start with a registered acknowledge decision. When a transfer is addressed to it, it reports which address matched and which direction the master asked for.

The block holds four address slots. In 7-bit mode all four slots serve as independent slave addresses. In 10-bit mode slots 0 and 1 together form one 10-bit address, and slots 2 and 3 still answer as 7-bit addresses. The block can also acknowledge the general call address. It decodes the byte that follows a general call and sets sticky flags that only an explicit clear strobe or a full reset removes. That decode includes a hardware general call, which is detected by comparing the second byte with a programmed alternate ID. A one-shot request lets the surrounding logic refuse the next transfer that would otherwise be acknowledged.

Top module: `i2c_addr_match`

## Requirements
- R1: While `slv_en` is 0, the recognizer state, any pending refuse request and every output except `gc_stat` and `gc_id` are held at 0. No byte produces `ack_vld`. Asynchronous `rst_n` low clears every output.
- R2: With `addr10_en` 0, a first byte whose bits 7:1 equal bits 7:1 of slot i is acknowledged with `match_idx` = i and `rd_dir` = byte bit 0. When several slots match, the lowest slot index wins.
- R3: With `addr10_en` 1, a first byte that equals slot 0 in bits 7:1 and has bit 0 = 0 is acknowledged while `match_vld` stays 0. A following byte equal to slot 1 is then acknowledged with `match_idx` = 5 and `rd_dir` = 0. Any other second byte is refused.
- R4: With `addr10_en` 1, slots 2 and 3 still match as 7-bit addresses, and slots 0 and 1 do not match as 7-bit addresses.
- R5: After a completed 10-bit match, a repeated start followed by the slot 0 first byte with bit 0 = 1 is acknowledged at once with `match_idx` = 5 and `rd_dir` = 1. After a fresh start, that byte is refused.
- R6: With `gc_en` 1, byte 0x00 is acknowledged with `match_idx` = 4 and `rd_dir` = 0, and `gc_stat` is set. With `gc_en` 0, byte 0x00 is refused. Byte 0x01 is never taken as a general call.
- R7: The byte after an acknowledged general call is acknowledged and sets `gc_id`. If `hgc_en` is 1 and the byte equals `alt_id`, `gc_id` becomes 3 and `hgc_hit` pulses for one cycle. Otherwise 0x06 gives 1 and 0x04 gives 2.
- R8: `gc_stat` and `gc_id` are cleared only by `gc_clr` or `rst_n`. Start, stop and `slv_en` = 0 leave them unchanged. A general call that arrives in the same cycle as `gc_clr` still sets `gc_stat`.
- R9: A `nack_req` pulse arms a one-shot refuse. The next byte that would be acknowledged is refused instead, the request is dropped, and the slave ignores the bus until the next start. Bytes that would be refused anyway leave the request armed.
- R10: `ack_vld` is a one-cycle pulse in the cycle after `byte_stb`, and `ack` is valid with it. `match_vld`, `match_idx` and `rd_dir` update on the same edge.
- R11: `match_vld` stays at 1 from the address acknowledge until a start, repeated start, stop or forced refuse. While it is 1, data bytes in the write direction get `ack` = 1 and bytes in the read direction get `ack` = 0.
- R12: After an address is refused, every further byte is answered with `ack` = 0 until the next start or repeated start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slv_en | input | 1 | Slave enable; 0 holds the recognizer in reset |
| start_stb | input | 1 | Start condition seen |
| rstart_stb | input | 1 | Repeated start seen |
| stop_stb | input | 1 | Stop condition seen |
| byte_stb | input | 1 | `rx_byte` holds a complete byte |
| rx_byte | input | 8 | Received byte |
| id_slots | input | 4x8 | Address slots, address in bits 7:1 |
| addr10_en | input | 1 | 10-bit mode on slots 0 and 1 |
| gc_en | input | 1 | Acknowledge the general call |
| hgc_en | input | 1 | Compare the byte after a general call with `alt_id` |
| alt_id | input | 8 | Alternate ID for the hardware general call |
| nack_req | input | 1 | Arm a one-shot refuse |
| gc_clr | input | 1 | Clear the general call flags |
| ack_vld | output | 1 | Decision for the last byte is valid |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| match_vld | output | 1 | Slave is addressed |
| match_idx | output | 3 | 0 to 3 slot, 4 general call, 5 10-bit address |
| rd_dir | output | 1 | Master reads |
| gc_stat | output | 1 | Sticky: a general call was acknowledged |
| gc_id | output | 2 | Sticky code of the byte after a general call |
| hgc_hit | output | 1 | One-cycle pulse on a hardware general call |

## Verification
Every result in this block comes from a single register stage. `ack_vld`, `ack`, the match outputs, the general call flags and `hgc_hit` all change on the first rising edge after the strobe that causes them. Each test drives a strobe on a falling edge and removes it on the next falling edge, then reads the outputs at that same falling edge, half a cycle after they were registered. The one-cycle width of the pulses is confirmed by sampling one falling edge later. Sticky and ignored cases are checked by reading the flags and the acknowledge outputs after the disturbing stimulus and before any further byte.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slv_en,
  input  logic            start_stb,
  input  logic            rstart_stb,
  input  logic            stop_stb,
  input  logic            byte_stb,
  input  logic [7:0]      rx_byte,
  input  logic [3:0][7:0] id_slots,
  input  logic            addr10_en,
  input  logic            gc_en,
  input  logic            hgc_en,
  input  logic [7:0]      alt_id,
  input  logic            nack_req,
  input  logic            gc_clr,
  output logic            ack_vld,
  output logic            ack,
  output logic            match_vld,
  output logic [2:0]      match_idx,
  output logic            rd_dir,
  output logic            gc_stat,
  output logic [1:0]      gc_id,
  output logic            hgc_hit
);

  localparam logic [2:0] IDX_GC  = 3'd4;
  localparam logic [2:0] IDX_TEN = 3'd5;
  localparam logic [7:0] GC_CODE_RST = 8'h06;
  localparam logic [7:0] GC_CODE_WR  = 8'h04;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADDR2, S_GC2, S_DATA, S_SKIP} st_t;

  st_t        st, nxt;
  logic       ten_sel, nack_arm;
  logic [3:0] slot_hit;
  logic [1:0] slot_idx;
  logic       want_ack, set_match, set_ten, new_rd;
  logic [2:0] new_idx;
  logic [1:0] gid_code;

  for (genvar i = 0; i < 4; i++) begin : g_slot
    assign slot_hit[i] = (!addr10_en || (i >= 2)) && (((rx_byte ^ id_slots[i]) & 8'hFE) == 8'h00);
  end

  always_comb begin
    slot_idx = 2'd0;
    for (int k = 3; k >= 0; k--)
      if (slot_hit[k]) slot_idx = k[1:0];
  end

  wire gc_hit    = gc_en && (rx_byte == 8'h00);
  wire ten_first = addr10_en && (((rx_byte ^ id_slots[0]) & 8'hFE) == 8'h00);
  wire ten_sec   = (rx_byte == id_slots[1]);
  wire alt_hit   = hgc_en && (rx_byte == alt_id);
  wire any_cond  = start_stb || rstart_stb || stop_stb;
  wire byte_go   = slv_en && byte_stb && !any_cond && (st != S_IDLE);
  wire nack_now  = byte_go && want_ack && nack_arm;
  wire take      = byte_go && !nack_now;

  always_comb begin
    want_ack  = 1'b0;
    nxt       = st;
    set_match = 1'b0;
    set_ten   = 1'b0;
    new_idx   = match_idx;
    new_rd    = rd_dir;
    case (st)
      S_ADDR: begin
        if (gc_hit) begin
          want_ack = 1'b1; nxt = S_GC2; set_match = 1'b1; new_idx = IDX_GC; new_rd = 1'b0;
        end else if (|slot_hit) begin
          want_ack = 1'b1; nxt = S_DATA; set_match = 1'b1; new_idx = {1'b0, slot_idx}; new_rd = rx_byte[0];
        end else if (ten_first && !rx_byte[0]) begin
          want_ack = 1'b1; nxt = S_ADDR2;
        end else if (ten_first && ten_sel) begin
          want_ack = 1'b1; nxt = S_DATA; set_match = 1'b1; new_idx = IDX_TEN; new_rd = 1'b1;
        end else begin
          nxt = S_SKIP;
        end
      end
      S_ADDR2: begin
        if (ten_sec) begin
          want_ack = 1'b1; nxt = S_DATA; set_match = 1'b1; set_ten = 1'b1; new_idx = IDX_TEN; new_rd = 1'b0;
        end else begin
          nxt = S_SKIP;
        end
      end
      S_GC2: begin
        want_ack = 1'b1; nxt = S_DATA;
      end
      S_DATA:  want_ack = !rd_dir;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ten_sel <= 1'b0; nack_arm <= 1'b0;
      ack_vld <= 1'b0; ack <= 1'b0; hgc_hit <= 1'b0;
      match_vld <= 1'b0; match_idx <= 3'd0; rd_dir <= 1'b0;
    end else if (!slv_en) begin
      st <= S_IDLE; ten_sel <= 1'b0; nack_arm <= 1'b0;
      ack_vld <= 1'b0; ack <= 1'b0; hgc_hit <= 1'b0;
      match_vld <= 1'b0; match_idx <= 3'd0; rd_dir <= 1'b0;
    end else begin
      ack_vld <= 1'b0;
      ack     <= 1'b0;
      hgc_hit <= 1'b0;
      if (nack_now) nack_arm <= 1'b0;
      if (nack_req) nack_arm <= 1'b1;
      if (stop_stb) begin
        st <= S_IDLE; ten_sel <= 1'b0; match_vld <= 1'b0;
      end else if (rstart_stb) begin
        st <= S_ADDR; match_vld <= 1'b0;
      end else if (start_stb) begin
        st <= S_ADDR; ten_sel <= 1'b0; match_vld <= 1'b0;
      end else if (byte_go) begin
        ack_vld <= 1'b1;
        if (nack_now) begin
          st <= S_SKIP; match_vld <= 1'b0;
        end else begin
          ack <= want_ack;
          st  <= nxt;
          if (set_match) begin
            match_vld <= 1'b1; match_idx <= new_idx; rd_dir <= new_rd;
          end
          if (set_ten) ten_sel <= 1'b1;
          if (st == S_GC2 && alt_hit) hgc_hit <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (alt_hit)                     gid_code = 2'd3;
    else if (rx_byte == GC_CODE_RST) gid_code = 2'd1;
    else if (rx_byte == GC_CODE_WR)  gid_code = 2'd2;
    else                             gid_code = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gc_stat <= 1'b0; gc_id <= 2'd0;
    end else begin
      if (gc_clr) begin
        gc_stat <= 1'b0; gc_id <= 2'd0;
      end
      if (take && st == S_ADDR && gc_hit) gc_stat <= 1'b1;
      if (take && st == S_GC2 && gid_code != 2'd0) gc_id <= gid_code;
    end
  end

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slv_en,
  input logic       byte_stb,
  input logic       stop_stb,
  input logic       gc_clr,
  input logic       ack_vld,
  input logic       ack,
  input logic       match_vld,
  input logic [2:0] match_idx,
  input logic       rd_dir,
  input logic       gc_stat,
  input logic [1:0] gc_id,
  input logic       hgc_hit
);

  p_ack_qual_r10: assert property (@(posedge clk) disable iff (!rst_n) ack |-> ack_vld);
  p_ack_after_byte_r10: assert property (@(posedge clk) disable iff (!rst_n) ack_vld |-> $past(byte_stb));
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n) !slv_en |=> (!ack_vld && !match_vld));
  p_idx_legal_r11: assert property (@(posedge clk) disable iff (!rst_n) match_vld |-> (match_idx <= 3'd5));
  p_stop_drops_r11: assert property (@(posedge clk) disable iff (!rst_n) stop_stb |=> !match_vld);
  p_gc_write_r6: assert property (@(posedge clk) disable iff (!rst_n) (match_vld && match_idx == 3'd4) |-> !rd_dir);
  p_gc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) (gc_stat && !gc_clr) |=> gc_stat);
  p_gcid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) (gc_id != 2'd0 && !gc_clr) |=> (gc_id != 2'd0));
  p_hgc_flags_r7: assert property (@(posedge clk) disable iff (!rst_n) hgc_hit |-> (gc_id == 2'd3 && gc_stat));

endmodule

bind i2c_addr_match i2c_addr_match_chk chk_i (.*);

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            slv_en = 1'b0;
  logic            start_stb = 1'b0, rstart_stb = 1'b0, stop_stb = 1'b0, byte_stb = 1'b0;
  logic [7:0]      rx_byte = 8'h00;
  logic [3:0][7:0] id_slots;
  logic            addr10_en = 1'b0, gc_en = 1'b0, hgc_en = 1'b0;
  logic [7:0]      alt_id = 8'h35;
  logic            nack_req = 1'b0, gc_clr = 1'b0;
  logic            ack_vld, ack, match_vld, rd_dir, gc_stat, hgc_hit;
  logic [2:0]      match_idx;
  logic [1:0]      gc_id;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  i2c_addr_match dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();  @(negedge clk); start_stb = 1;  @(negedge clk); start_stb = 0;  endtask
  task automatic pulse_rstart(); @(negedge clk); rstart_stb = 1; @(negedge clk); rstart_stb = 0; endtask
  task automatic pulse_stop();   @(negedge clk); stop_stb = 1;   @(negedge clk); stop_stb = 0;   endtask
  task automatic pulse_clr();    @(negedge clk); gc_clr = 1;     @(negedge clk); gc_clr = 0;     endtask
  task automatic pulse_nreq();   @(negedge clk); nack_req = 1;   @(negedge clk); nack_req = 0;   endtask

  task automatic xfer(input logic [7:0] b, input string tag, input logic exp_ack);
    @(negedge clk); rx_byte = b; byte_stb = 1;
    @(negedge clk); byte_stb = 0;
    chk({tag, " ack_vld"}, ack_vld, 1);
    chk({tag, " ack"}, ack, exp_ack);
  endtask

  task automatic t_reset();
    chk("R1 reset ack_vld", ack_vld, 0);
    chk("R1 reset match_vld", match_vld, 0);
    chk("R1 reset gc_stat", gc_stat, 0);
    chk("R1 reset gc_id", gc_id, 0);
    chk("R1 reset hgc_hit", hgc_hit, 0);
  endtask

  task automatic t_seven();
    pulse_start();
    xfer(8'h51, "R2 slot0 read", 1);
    chk("R2 slot0 idx", match_idx, 0);
    chk("R2 slot0 rd", rd_dir, 1);
    chk("R10 match_vld same edge", match_vld, 1);
    @(negedge clk);
    chk("R10 ack_vld one cycle", ack_vld, 0);
    pulse_stop();
    chk("R11 stop drops match", match_vld, 0);
    pulse_start();
    xfer(8'hA0, "R2 slot1 write", 1);
    chk("R2 slot1 idx", match_idx, 1);
    chk("R2 slot1 rd", rd_dir, 0);
    xfer(8'h33, "R11 write data", 1);
    chk("R11 match held", match_vld, 1);
    pulse_rstart();
    chk("R11 rstart drops match", match_vld, 0);
    id_slots[3] = 8'h62;
    xfer(8'h63, "R2 lowest wins", 1);
    chk("R2 lowest idx", match_idx, 2);
    id_slots[3] = 8'h7E;
    pulse_stop();
    pulse_start();
    xfer(8'h7E, "R2 slot3", 1);
    chk("R2 slot3 idx", match_idx, 3);
    pulse_stop();
    pulse_start();
    xfer(8'h10, "R12 unmatched", 0);
    xfer(8'h55, "R12 skipped data", 0);
    chk("R12 no match", match_vld, 0);
    pulse_stop();
  endtask

  task automatic t_tenbit();
    addr10_en = 1; id_slots[0] = 8'hF2; id_slots[1] = 8'h5A;
    pulse_start();
    xfer(8'hF2, "R3 first byte", 1);
    chk("R3 not yet matched", match_vld, 0);
    xfer(8'h5A, "R3 second byte", 1);
    chk("R3 idx", match_idx, 5);
    chk("R3 rd", rd_dir, 0);
    xfer(8'h11, "R3 data", 1);
    pulse_rstart();
    xfer(8'hF3, "R5 reselect", 1);
    chk("R5 idx", match_idx, 5);
    chk("R5 rd", rd_dir, 1);
    pulse_stop();
    pulse_start();
    xfer(8'hF3, "R5 fresh start refused", 0);
    pulse_stop();
    pulse_start();
    xfer(8'hF2, "R3 first again", 1);
    xfer(8'h5B, "R3 wrong second", 0);
    chk("R3 wrong no match", match_vld, 0);
    pulse_stop();
    pulse_start();
    xfer(8'h62, "R4 slot2 in 10-bit", 1);
    chk("R4 slot2 idx", match_idx, 2);
    pulse_stop();
    pulse_start();
    xfer(8'h5A, "R4 slot1 not 7-bit", 0);
    pulse_stop();
    addr10_en = 0; id_slots[0] = 8'h50; id_slots[1] = 8'hA0;
  endtask

  task automatic t_gencall();
    pulse_start();
    xfer(8'h00, "R6 gc disabled", 0);
    pulse_stop();
    gc_en = 1;
    pulse_start();
    xfer(8'h00, "R6 gc", 1);
    chk("R6 gc idx", match_idx, 4);
    chk("R6 gc rd", rd_dir, 0);
    chk("R6 gc_stat", gc_stat, 1);
    xfer(8'h06, "R7 code 06", 1);
    chk("R7 gc_id 1", gc_id, 1);
    pulse_stop();
    pulse_start();
    chk("R8 gc_stat kept", gc_stat, 1);
    chk("R8 gc_id kept", gc_id, 1);
    pulse_stop();
    pulse_clr();
    chk("R8 clr gc_stat", gc_stat, 0);
    chk("R8 clr gc_id", gc_id, 0);
    pulse_start();
    xfer(8'h00, "R6 gc again", 1);
    xfer(8'h04, "R7 code 04", 1);
    chk("R7 gc_id 2", gc_id, 2);
    pulse_stop();
    pulse_clr();
    hgc_en = 1;
    pulse_start();
    xfer(8'h00, "R7 gc before hw", 1);
    xfer(8'h35, "R7 hw gc byte", 1);
    chk("R7 hgc_hit", hgc_hit, 1);
    chk("R7 gc_id 3", gc_id, 3);
    @(negedge clk);
    chk("R7 hgc_hit pulse", hgc_hit, 0);
    pulse_stop();
    @(negedge clk); slv_en = 0;
    @(negedge clk); @(negedge clk); slv_en = 1;
    chk("R8 disable keeps gc_stat", gc_stat, 1);
    chk("R8 disable keeps gc_id", gc_id, 3);
    pulse_start();
    xfer(8'h01, "R6 gc read refused", 0);
    pulse_stop();
    pulse_start();
    @(negedge clk); rx_byte = 8'h00; byte_stb = 1; gc_clr = 1;
    @(negedge clk); byte_stb = 0; gc_clr = 0;
    chk("R8 set wins gc_stat", gc_stat, 1);
    chk("R8 clr gc_id", gc_id, 0);
    pulse_stop();
    pulse_clr();
    gc_en = 0; hgc_en = 0;
  endtask

  task automatic t_nackreq();
    pulse_nreq();
    pulse_start();
    xfer(8'h10, "R9 unmatched keeps request", 0);
    pulse_stop();
    pulse_start();
    xfer(8'h50, "R9 forced refuse", 0);
    chk("R9 no match", match_vld, 0);
    xfer(8'h22, "R9 ignored after refuse", 0);
    pulse_stop();
    pulse_start();
    xfer(8'h50, "R9 one-shot", 1);
    xfer(8'h22, "R9 data ack", 1);
    pulse_nreq();
    xfer(8'h23, "R9 data refuse", 0);
    chk("R9 data drop match", match_vld, 0);
    pulse_stop();
  endtask

  task automatic t_disable();
    pulse_start();
    xfer(8'h50, "R1 pre-disable", 1);
    @(negedge clk); slv_en = 0;
    @(negedge clk);
    chk("R1 disable drops match", match_vld, 0);
    @(negedge clk); rx_byte = 8'h50; byte_stb = 1;
    @(negedge clk); byte_stb = 0;
    chk("R1 disabled no ack_vld", ack_vld, 0);
    slv_en = 1;
    pulse_nreq();
    @(negedge clk); slv_en = 0;
    @(negedge clk); slv_en = 1;
    pulse_start();
    xfer(8'h50, "R1 request dropped", 1);
    pulse_stop();
  endtask

  task automatic t_readdir();
    pulse_start();
    xfer(8'h51, "R11 read addr", 1);
    xfer(8'h99, "R11 read data", 0);
    chk("R11 read match held", match_vld, 1);
    pulse_rstart();
    chk("R11 rstart clears", match_vld, 0);
    pulse_stop();
  endtask

  initial begin
    id_slots[0] = 8'h50; id_slots[1] = 8'hA0; id_slots[2] = 8'h62; id_slots[3] = 8'h7E;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    slv_en = 1;
    @(negedge clk);
    t_seven();
    t_tenbit();
    t_gencall();
    t_nackreq();
    t_disable();
    t_readdir();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule